// File: doc/BRIEF.md
# Coprocessor Mailbox and Control Register Decoder

This block sits on the local bus of an audio coprocessor and answers the sixteen-byte I/O window at the top of page zero (0x00F0 to 0x00FF). It holds a configuration byte, a control byte, an indirect address/data window onto a 128-entry DSP register space, two general-purpose bytes and four mailbox channels. Each mailbox channel has two latches: one written by the host CPU and read locally, and one written locally and read by the host.

Local reads are combinational. The read data is valid in the same cycle as the read strobe and the address. Local writes take effect at the next rising clock edge. The host side has its own port index, write strobe and read strobe. Timer counters live elsewhere: this block only exports the timer enables, a one-cycle clear pulse when an enable rises, and a per-timer strobe for loading the target value. The target value itself is taken from the local write data.

Top module: `cop_mmio_regs`

## Requirements
- R1: After reset all held bytes read 0x00, every configuration output, timer enable and clear pulse is 0, and `boot_rom_en` is 1.
- R2: A local write to 0x00F0 with `p_flag` high changes nothing. With `p_flag` low it loads the configuration outputs as follows: bit0 `cfg_tmr_halt`, bit1 `cfg_ram_wr_en`, bit2 `cfg_ram_off`, bit3 `cfg_tmr_on`, bits5:4 `cfg_ext_wait`, bits7:6 `cfg_int_wait`.
- R3: Local reads of 0x00F0, 0x00F1, 0x00FA, 0x00FB and 0x00FC return 0x00.
- R4: A write to 0x00F1 loads `tmr_en` from bits2:0. In the following cycle, `tmr_clr[i]` is high for exactly one cycle for each timer whose enable went from 0 to 1.
- R5: In a write to 0x00F1, bit4 set clears outbound mailboxes 0 and 1, bit5 set clears outbound mailboxes 2 and 3, and bit7 is loaded into `boot_rom_en`.
- R6: 0x00F2 is a read/write DSP address byte and `dsp_addr` carries its low 7 bits. A read of 0x00F3 raises `dsp_rd` and returns `dsp_rdata` in the same cycle.
- R7: A write to 0x00F3 raises `dsp_wr` with `dsp_wdata` equal to the write data, but only when bit7 of the DSP address byte is 0. Addresses 0x80 to 0xFF therefore act as read-only mirrors.
- R8: Local reads of 0x00F4 to 0x00F7 return the inbound byte that the host last wrote with `host_idx` 0 to 3 respectively.
- R9: Local writes to 0x00F4 to 0x00F7 load outbound mailboxes 0 to 3. `host_rdata` returns outbound mailbox `host_idx` while `host_rd` is high, and returns 0x00 otherwise. Local reads never return an outbound byte.
- R10: 0x00F8 and 0x00F9 are plain read/write bytes.
- R11: `loc_hit` is high exactly for addresses 0x00F0 to 0x00FC. For every other address, reads return 0x00 and writes change no state and raise no strobe.
- R12: A write to 0x00FA, 0x00FB or 0x00FC raises `tgt_we` bit 0, 1 or 2 respectively, in the same cycle. At most one bit is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_addr | input | 16 | Local bus address |
| loc_wdata | input | 8 | Local write data |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| p_flag | input | 1 | Processor direct-page flag; high locks the configuration byte |
| loc_rdata | output | 8 | Local read data, zero when no read is in progress |
| loc_hit | output | 1 | Address falls on a register of this block |
| host_idx | input | 2 | Host mailbox index |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Outbound mailbox byte to host |
| dsp_addr | output | 7 | DSP register index |
| dsp_rd | output | 1 | DSP register read strobe |
| dsp_wr | output | 1 | DSP register write strobe |
| dsp_wdata | output | 8 | DSP register write data |
| dsp_rdata | input | 8 | DSP register read data |
| cfg_tmr_halt | output | 1 | Timer halt configuration bit |
| cfg_ram_wr_en | output | 1 | RAM write enable configuration bit |
| cfg_ram_off | output | 1 | RAM disable configuration bit |
| cfg_tmr_on | output | 1 | Timer run configuration bit |
| cfg_ext_wait | output | 2 | External wait-state count |
| cfg_int_wait | output | 2 | Internal wait-state count |
| boot_rom_en | output | 1 | Boot ROM overlay enable |
| tmr_en | output | 3 | Timer enables |
| tmr_clr | output | 3 | One-cycle timer clear pulses |
| tgt_we | output | 3 | Timer target load strobes |

## Verification
The assertions assume that `loc_addr`, the strobes and `p_flag` carry known values once reset is released. They also assume that the local read and write strobes are never high in the same cycle, so that the read-back-zero and mirror checks see one access at a time. The stimulus drives every input to a defined value at all times. It raises at most one local strobe per cycle, while letting host accesses overlap local accesses freely. Its randomised phase draws addresses mostly from the window and sometimes from outside it.

// File: rtl/cop_mmio_pkg.sv
package cop_mmio_pkg;

    // Register selected by the low address nibble
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TEST,
        SEL_CTRL,
        SEL_DADDR,
        SEL_DDATA,
        SEL_PORT,
        SEL_AUX,
        SEL_TGT
    } sel_e;

    // Configuration byte layout (field positions are software-visible)
    typedef struct packed {
        logic [1:0] int_wait;   // bits 7:6
        logic [1:0] ext_wait;   // bits 5:4
        logic       tmr_on;     // bit 3
        logic       ram_off;    // bit 2
        logic       ram_wr_en;  // bit 1
        logic       tmr_halt;   // bit 0
    } test_t;

    // Low-nibble offsets inside the window
    localparam logic [3:0] OFS_TEST  = 4'h0;
    localparam logic [3:0] OFS_CTRL  = 4'h1;
    localparam logic [3:0] OFS_DADDR = 4'h2;
    localparam logic [3:0] OFS_DDATA = 4'h3;
    localparam logic [3:0] OFS_PORT0 = 4'h4;
    localparam logic [3:0] OFS_AUX0  = 4'h8;
    localparam logic [3:0] OFS_TGT0  = 4'hA;

    // Control byte bit positions
    localparam int CTRL_CLR_LO = 4;
    localparam int CTRL_ROM    = 7;

endpackage

// File: rtl/cop_addr_decode.sv
module cop_addr_decode
    import cop_mmio_pkg::*;
#(
    parameter int unsigned    AW   = 16,
    parameter int unsigned    NPRT = 4,
    parameter int unsigned    NAUX = 2,
    parameter int unsigned    NTMR = 3,
    parameter logic [AW-1:0]  BASE = 16'h00F0
) (
    input  logic [AW-1:0] addr,
    output sel_e          sel,
    output logic [1:0]    idx,
    output logic          hit
);
    logic       in_rng;
    logic [3:0] lo;

    assign in_rng = (addr[AW-1:4] == BASE[AW-1:4]);
    assign lo     = addr[3:0];

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (in_rng) begin
            if (lo == OFS_TEST) begin
                sel = SEL_TEST;
            end else if (lo == OFS_CTRL) begin
                sel = SEL_CTRL;
            end else if (lo == OFS_DADDR) begin
                sel = SEL_DADDR;
            end else if (lo == OFS_DDATA) begin
                sel = SEL_DDATA;
            end else if (lo >= OFS_PORT0 && lo < OFS_PORT0 + 4'(NPRT)) begin
                sel = SEL_PORT;
                idx = 2'(lo - OFS_PORT0);
            end else if (lo >= OFS_AUX0 && lo < OFS_AUX0 + 4'(NAUX)) begin
                sel = SEL_AUX;
                idx = 2'(lo - OFS_AUX0);
            end else if (lo >= OFS_TGT0 && lo < OFS_TGT0 + 4'(NTMR)) begin
                sel = SEL_TGT;
                idx = 2'(lo - OFS_TGT0);
            end
        end
    end

    assign hit = (sel != SEL_NONE);

endmodule

// File: rtl/cop_ctrl_regs.sv
module cop_ctrl_regs
    import cop_mmio_pkg::*;
#(
    parameter int unsigned DW   = 8,
    parameter int unsigned NTMR = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            test_we,
    input  logic            ctrl_we,
    input  logic [DW-1:0]   wdata,
    output test_t           test_q,
    output logic [NTMR-1:0] tmr_en_q,
    output logic [NTMR-1:0] tmr_clr_q,
    output logic            rom_en_q,
    output logic [1:0]      clr_grp
);
    // R2 configuration byte, R4 timer enables and rise pulse, R5 ROM enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q    <= '0;
            tmr_en_q  <= '0;
            tmr_clr_q <= '0;
            rom_en_q  <= 1'b1;
        end else begin
            tmr_clr_q <= ctrl_we ? (wdata[NTMR-1:0] & ~tmr_en_q) : '0;
            if (test_we) begin
                test_q <= test_t'(wdata[7:0]);
            end
            if (ctrl_we) begin
                tmr_en_q <= wdata[NTMR-1:0];
                rom_en_q <= wdata[CTRL_ROM];
            end
        end
    end

    // R5 outbound clear groups: bit4 ports 0/1, bit5 ports 2/3
    assign clr_grp = ctrl_we ? wdata[CTRL_CLR_LO+1:CTRL_CLR_LO] : 2'b00;

endmodule

// File: rtl/cop_mailbox.sv
module cop_mailbox #(
    parameter int unsigned DW   = 8,
    parameter int unsigned NPRT = 4,
    localparam int unsigned IW  = (NPRT > 1) ? $clog2(NPRT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     loc_we,
    input  logic [IW-1:0]            loc_idx,
    input  logic [DW-1:0]            loc_wdata,
    input  logic [1:0]               clr_grp,
    input  logic                     host_we,
    input  logic [IW-1:0]            host_idx,
    input  logic [DW-1:0]            host_wdata,
    output logic [NPRT-1:0][DW-1:0]  inbox_q,
    output logic [NPRT-1:0][DW-1:0]  outbox_q
);
    for (genvar p = 0; p < NPRT; p++) begin : g_port
        localparam int GRP = p / 2;

        // R8 inbound latch, written by the host
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                inbox_q[p] <= '0;
            end else if (host_we && host_idx == IW'(p)) begin
                inbox_q[p] <= host_wdata;
            end
        end

        // R9 outbound latch, written locally; R5 group clear wins
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                outbox_q[p] <= '0;
            end else if (clr_grp[GRP]) begin
                outbox_q[p] <= '0;
            end else if (loc_we && loc_idx == IW'(p)) begin
                outbox_q[p] <= loc_wdata;
            end
        end
    end

endmodule

// File: rtl/cop_mmio_regs.sv
module cop_mmio_regs
    import cop_mmio_pkg::*;
#(
    parameter int unsigned    AW     = 16,
    parameter int unsigned    DW     = 8,
    parameter int unsigned    NPRT   = 4,
    parameter int unsigned    NAUX   = 2,
    parameter int unsigned    NTMR   = 3,
    parameter int unsigned    DSP_AW = 7,
    parameter logic [AW-1:0]  BASE   = 16'h00F0,
    localparam int unsigned   IW     = (NPRT > 1) ? $clog2(NPRT) : 1,
    localparam int unsigned   XW     = (NAUX > 1) ? $clog2(NAUX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     loc_addr,
    input  logic [DW-1:0]     loc_wdata,
    input  logic              loc_wr,
    input  logic              loc_rd,
    input  logic              p_flag,
    output logic [DW-1:0]     loc_rdata,
    output logic              loc_hit,
    input  logic [IW-1:0]     host_idx,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic [DSP_AW-1:0] dsp_addr,
    output logic              dsp_rd,
    output logic              dsp_wr,
    output logic [DW-1:0]     dsp_wdata,
    input  logic [DW-1:0]     dsp_rdata,
    output logic              cfg_tmr_halt,
    output logic              cfg_ram_wr_en,
    output logic              cfg_ram_off,
    output logic              cfg_tmr_on,
    output logic [1:0]        cfg_ext_wait,
    output logic [1:0]        cfg_int_wait,
    output logic              boot_rom_en,
    output logic [NTMR-1:0]   tmr_en,
    output logic [NTMR-1:0]   tmr_clr,
    output logic [NTMR-1:0]   tgt_we
);
    sel_e                    sel;
    logic [1:0]              idx;
    test_t                   test_q;
    logic [1:0]              clr_grp;
    logic [DW-1:0]           dsp_addr_q;
    logic [NAUX-1:0][DW-1:0] aux_q;
    logic [NPRT-1:0][DW-1:0] inbox_q;
    logic [NPRT-1:0][DW-1:0] outbox_q;

    cop_addr_decode #(
        .AW(AW), .NPRT(NPRT), .NAUX(NAUX), .NTMR(NTMR), .BASE(BASE)
    ) u_dec (
        .addr (loc_addr),
        .sel  (sel),
        .idx  (idx),
        .hit  (loc_hit)
    );

    cop_ctrl_regs #(.DW(DW), .NTMR(NTMR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_we   (loc_wr && sel == SEL_TEST && !p_flag),
        .ctrl_we   (loc_wr && sel == SEL_CTRL),
        .wdata     (loc_wdata),
        .test_q    (test_q),
        .tmr_en_q  (tmr_en),
        .tmr_clr_q (tmr_clr),
        .rom_en_q  (boot_rom_en),
        .clr_grp   (clr_grp)
    );

    cop_mailbox #(.DW(DW), .NPRT(NPRT)) u_mbox (
        .clk        (clk),
        .rst_n      (rst_n),
        .loc_we     (loc_wr && sel == SEL_PORT),
        .loc_idx    (idx[IW-1:0]),
        .loc_wdata  (loc_wdata),
        .clr_grp    (clr_grp),
        .host_we    (host_wr),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .inbox_q    (inbox_q),
        .outbox_q   (outbox_q)
    );

    // R6 DSP address byte, R10 auxiliary bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsp_addr_q <= '0;
        end else if (loc_wr && sel == SEL_DADDR) begin
            dsp_addr_q <= loc_wdata;
        end
    end

    for (genvar a = 0; a < NAUX; a++) begin : g_aux
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                aux_q[a] <= '0;
            end else if (loc_wr && sel == SEL_AUX && idx[XW-1:0] == XW'(a)) begin
                aux_q[a] <= loc_wdata;
            end
        end
    end

    // R12 target load strobes
    for (genvar t = 0; t < NTMR; t++) begin : g_tgt
        assign tgt_we[t] = loc_wr && sel == SEL_TGT && idx == 2'(t);
    end

    // R6/R7 DSP window with read-only upper mirror
    assign dsp_addr  = dsp_addr_q[DSP_AW-1:0];
    assign dsp_rd    = loc_rd && sel == SEL_DDATA;
    assign dsp_wr    = loc_wr && sel == SEL_DDATA && !dsp_addr_q[DW-1];
    assign dsp_wdata = loc_wdata;

    assign {cfg_int_wait, cfg_ext_wait, cfg_tmr_on,
            cfg_ram_off, cfg_ram_wr_en, cfg_tmr_halt} = test_q;

    // R9 host side sees only outbound latches
    assign host_rdata = host_rd ? outbox_q[host_idx] : '0;

    // R3/R8/R11 local read mux; write-only registers fall to zero
    always_comb begin
        loc_rdata = '0;
        if (loc_rd) begin
            unique case (sel)
                SEL_DADDR: loc_rdata = dsp_addr_q;
                SEL_DDATA: loc_rdata = dsp_rdata;
                SEL_PORT:  loc_rdata = inbox_q[idx[IW-1:0]];
                SEL_AUX:   loc_rdata = aux_q[idx[XW-1:0]];
                default:   loc_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cop_mmio_regs_chk.sv
module cop_mmio_regs_chk
    import cop_mmio_pkg::*;
#(
    parameter int unsigned    AW   = 16,
    parameter int unsigned    DW   = 8,
    parameter int unsigned    NPRT = 4,
    parameter int unsigned    NTMR = 3,
    parameter logic [AW-1:0]  BASE = 16'h00F0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [AW-1:0]            loc_addr,
    input logic [DW-1:0]            loc_wdata,
    input logic                     loc_wr,
    input logic                     loc_rd,
    input logic                     p_flag,
    input logic [DW-1:0]            loc_rdata,
    input logic                     loc_hit,
    input logic                     host_rd,
    input logic [DW-1:0]            host_rdata,
    input logic                     dsp_wr,
    input logic [DW-1:0]            dsp_addr_q,
    input logic [NPRT-1:0][DW-1:0]  outbox_q,
    input test_t                    test_q,
    input logic [NTMR-1:0]          tmr_en,
    input logic [NTMR-1:0]          tmr_clr,
    input logic [NTMR-1:0]          tgt_we
);
    logic       in_rng;
    logic [3:0] lo;
    logic       wo_addr;

    assign in_rng  = (loc_addr[AW-1:4] == BASE[AW-1:4]);
    assign lo      = loc_addr[3:0];
    assign wo_addr = in_rng && (lo == 4'h0 || lo == 4'h1 || lo == 4'hA ||
                                lo == 4'hB || lo == 4'hC);

    AST_TEST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && in_rng && lo == 4'h0 && p_flag) |=> $stable(test_q)); // R2

    AST_TEST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && in_rng && lo == 4'h0 && !p_flag) |=> (test_q == $past(loc_wdata))); // R2

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd && wo_addr) |-> (loc_rdata == '0)); // R3

    AST_CLR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((tmr_clr & ~(tmr_en & ~$past(tmr_en))) == '0)); // R4

    AST_CLR_LO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && in_rng && lo == 4'h1 && loc_wdata[4])
        |=> (outbox_q[0] == '0 && outbox_q[1] == '0)); // R5

    AST_CLR_HI_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && in_rng && lo == 4'h1 && loc_wdata[5])
        |=> (outbox_q[2] == '0 && outbox_q[3] == '0)); // R5

    AST_MIRROR_RO: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_wr |-> !dsp_addr_q[DW-1]); // R7

    AST_HOST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> (host_rdata == '0)); // R9

    AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rng |-> (!loc_hit && loc_rdata == '0 && tgt_we == '0 && !dsp_wr)); // R11

    AST_TGT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_we)); // R12

endmodule

bind cop_mmio_regs cop_mmio_regs_chk #(
    .AW(AW), .DW(DW), .NPRT(NPRT), .NTMR(NTMR), .BASE(BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .loc_addr   (loc_addr),
    .loc_wdata  (loc_wdata),
    .loc_wr     (loc_wr),
    .loc_rd     (loc_rd),
    .p_flag     (p_flag),
    .loc_rdata  (loc_rdata),
    .loc_hit    (loc_hit),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .dsp_wr     (dsp_wr),
    .dsp_addr_q (dsp_addr_q),
    .outbox_q   (outbox_q),
    .test_q     (test_q),
    .tmr_en     (tmr_en),
    .tmr_clr    (tmr_clr),
    .tgt_we     (tgt_we)
);

// File: tb/tb_cop_mmio_regs.sv
`timescale 1ns/1ps
module tb_cop_mmio_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] loc_addr = 16'h0000;
    logic [7:0]  loc_wdata = 8'h00;
    logic        loc_wr = 1'b0, loc_rd = 1'b0, p_flag = 1'b0;
    logic [7:0]  loc_rdata;
    logic        loc_hit;
    logic [1:0]  host_idx = 2'd0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00, host_rdata;
    logic [6:0]  dsp_addr;
    logic        dsp_rd, dsp_wr;
    logic [7:0]  dsp_wdata, dsp_rdata;
    logic        cfg_tmr_halt, cfg_ram_wr_en, cfg_ram_off, cfg_tmr_on;
    logic [1:0]  cfg_ext_wait, cfg_int_wait;
    logic        boot_rom_en;
    logic [2:0]  tmr_en, tmr_clr, tgt_we;

    always #10 clk = ~clk;   // 50 MHz

    // Bench-side DSP register file, fixed contents
    logic [7:0] dsp_mem [128];
    initial for (int i = 0; i < 128; i++) dsp_mem[i] = 8'((i * 37 + 11) ^ 8'h5A);
    assign dsp_rdata = dsp_mem[dsp_addr];

    cop_mmio_regs dut (
        .clk(clk), .rst_n(rst_n), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_wr(loc_wr), .loc_rd(loc_rd), .p_flag(p_flag), .loc_rdata(loc_rdata),
        .loc_hit(loc_hit), .host_idx(host_idx), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .dsp_addr(dsp_addr),
        .dsp_rd(dsp_rd), .dsp_wr(dsp_wr), .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
        .cfg_tmr_halt(cfg_tmr_halt), .cfg_ram_wr_en(cfg_ram_wr_en),
        .cfg_ram_off(cfg_ram_off), .cfg_tmr_on(cfg_tmr_on),
        .cfg_ext_wait(cfg_ext_wait), .cfg_int_wait(cfg_int_wait),
        .boot_rom_en(boot_rom_en), .tmr_en(tmr_en), .tmr_clr(tmr_clr), .tgt_we(tgt_we)
    );

    // Behavioural reference state
    logic [7:0] m_cfg, m_daddr;
    logic [2:0] m_en, m_clr;
    logic       m_rom;
    logic [7:0] m_in [4];
    logic [7:0] m_out [4];
    logic [7:0] m_aux [2];

    int nchk = 0, nerr = 0;
    bit done = 0;

    function automatic bit in_win(logic [15:0] a);
        return a[15:4] == 12'h00F;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_daddr = 0; m_en = 0; m_clr = 0; m_rom = 1;
            for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_out[i] = 0; end
            m_aux[0] = 0; m_aux[1] = 0;
        end else begin
            m_clr = 0;
            if (loc_wr && in_win(loc_addr)) begin
                case (loc_addr[3:0])
                    4'h0: if (!p_flag) m_cfg = loc_wdata;
                    4'h1: begin
                        m_clr = loc_wdata[2:0] & ~m_en;
                        m_en  = loc_wdata[2:0];
                        if (loc_wdata[4]) begin m_out[0] = 0; m_out[1] = 0; end
                        if (loc_wdata[5]) begin m_out[2] = 0; m_out[3] = 0; end
                        m_rom = loc_wdata[7];
                    end
                    4'h2: m_daddr = loc_wdata;
                    4'h4, 4'h5, 4'h6, 4'h7: m_out[loc_addr[1:0]] = loc_wdata;
                    4'h8, 4'h9: m_aux[loc_addr[0]] = loc_wdata;
                    default: ;
                endcase
            end
            if (host_wr) m_in[host_idx] = host_wdata;
        end
    end

    task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rd_tag(logic [15:0] a);
        if (!in_win(a)) return "R11 rdata";
        case (a[3:0])
            4'h0, 4'h1, 4'hA, 4'hB, 4'hC: return "R3 rdata";
            4'h2, 4'h3: return "R6 rdata";
            4'h4, 4'h5, 4'h6, 4'h7: return "R8 rdata";
            4'h8, 4'h9: return "R10 rdata";
            default: return "R11 rdata";
        endcase
    endfunction

    // Compare all outputs against the model on every falling edge
    always @(negedge clk) begin
        logic [7:0] e_rd;
        logic [2:0] e_tgt;
        bit         w;
        bit         rst_chk;
        if (!done) begin
            w = in_win(loc_addr);
            rst_chk = (m_cfg == 0 && m_rom && m_en == 0);
            e_rd = 0;
            if (loc_rd && w) begin
                case (loc_addr[3:0])
                    4'h2: e_rd = m_daddr;
                    4'h3: e_rd = dsp_mem[m_daddr[6:0]];
                    4'h4, 4'h5, 4'h6, 4'h7: e_rd = m_in[loc_addr[1:0]];
                    4'h8, 4'h9: e_rd = m_aux[loc_addr[0]];
                    default: e_rd = 0;
                endcase
            end
            e_tgt = 0;
            if (loc_wr && w && loc_addr[3:0] >= 4'hA && loc_addr[3:0] <= 4'hC)
                e_tgt[loc_addr[3:0] - 4'hA] = 1'b1;
            if (!rst_n) begin
                cmp("R1 cfg", {cfg_int_wait, cfg_ext_wait, cfg_tmr_on, cfg_ram_off,
                               cfg_ram_wr_en, cfg_tmr_halt}, 8'h00);
                cmp("R1 rom", {7'd0, boot_rom_en}, 8'h01);
                cmp("R1 tmr", {2'd0, tmr_clr, tmr_en}, 8'h00);
            end else begin
                cmp(rst_chk ? "R1 R2 cfg" : "R2 cfg",
                    {cfg_int_wait, cfg_ext_wait, cfg_tmr_on, cfg_ram_off,
                     cfg_ram_wr_en, cfg_tmr_halt}, m_cfg);
                cmp("R4 tmr_en", {5'd0, tmr_en}, {5'd0, m_en});
                cmp("R4 tmr_clr", {5'd0, tmr_clr}, {5'd0, m_clr});
                cmp("R5 boot_rom_en", {7'd0, boot_rom_en}, {7'd0, m_rom});
                cmp(rd_tag(loc_addr), loc_rdata, e_rd);
                cmp("R11 loc_hit", {7'd0, loc_hit},
                    {7'd0, w && loc_addr[3:0] <= 4'hC});
                cmp("R6 dsp_addr", {1'b0, dsp_addr}, {1'b0, m_daddr[6:0]});
                cmp("R6 dsp_rd", {7'd0, dsp_rd},
                    {7'd0, loc_rd && w && loc_addr[3:0] == 4'h3});
                cmp("R7 dsp_wr", {7'd0, dsp_wr},
                    {7'd0, loc_wr && w && loc_addr[3:0] == 4'h3 && !m_daddr[7]});
                if (dsp_wr) cmp("R7 dsp_wdata", dsp_wdata, loc_wdata);
                cmp("R5 R9 host_rdata", host_rdata, host_rd ? m_out[host_idx] : 8'h00);
                cmp("R12 tgt_we", {5'd0, tgt_we}, {5'd0, e_tgt});
            end
        end
    end

    // One bus cycle: inputs change 2 ns after the rising edge
    task automatic step(logic [15:0] a, logic [7:0] d, bit wr, bit rd, bit p,
                        logic [1:0] hi, bit hw, bit hr, logic [7:0] hd);
        loc_addr = a; loc_wdata = d; loc_wr = wr; loc_rd = rd; p_flag = p;
        host_idx = hi; host_wr = hw; host_rd = hr; host_wdata = hd;
        @(posedge clk); #2;
        loc_wr = 0; loc_rd = 0; host_wr = 0; host_rd = 0;
    endtask

    task automatic lw(logic [15:0] a, logic [7:0] d, bit p = 0);
        step(a, d, 1, 0, p, 0, 0, 0, 0);
    endtask
    task automatic lr(logic [15:0] a);
        step(a, 0, 0, 1, 0, 0, 0, 0, 0);
    endtask
    task automatic hw(logic [1:0] i, logic [7:0] d);
        step(16'h0000, 0, 0, 0, 0, i, 1, 0, d);
    endtask
    task automatic hr(logic [1:0] i);
        step(16'h0000, 0, 0, 0, 0, i, 0, 1, 0);
    endtask

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1 reset reads
        lr(16'h00F0); lr(16'h00F2); lr(16'h00F4); lr(16'h00F8); hr(2'd1);
        // R2 locked and open configuration writes
        lw(16'h00F0, 8'hA6, 1); lr(16'h00F0);
        lw(16'h00F0, 8'hC9, 0); lr(16'h00F0);
        // R4 timer enables and rise pulses, R5 ROM enable
        lw(16'h00F1, 8'h85); lw(16'h00F1, 8'h87); lw(16'h00F1, 8'h87);
        lw(16'h00F1, 8'h02); lr(16'h00F1); lw(16'h00F1, 8'h81);
        // R9 outbound latches, R5 group clears
        lw(16'h00F4, 8'h11); lw(16'h00F5, 8'h22); lw(16'h00F6, 8'h33); lw(16'h00F7, 8'h44);
        for (int i = 0; i < 4; i++) hr(2'(i));
        lr(16'h00F4); lr(16'h00F7);
        lw(16'h00F1, 8'h91); hr(2'd0); hr(2'd1); hr(2'd2);
        lw(16'h00F1, 8'hA1); hr(2'd3); hr(2'd2);
        // R8 inbound latches
        for (int i = 0; i < 4; i++) hw(2'(i), 8'(8'hB0 + i));
        for (int i = 0; i < 4; i++) lr(16'h00F4 + 16'(i));
        // R6/R7 DSP window and mirror
        lw(16'h00F2, 8'h15); lr(16'h00F2); lr(16'h00F3); lw(16'h00F3, 8'h77);
        lw(16'h00F2, 8'h95); lr(16'h00F3); lw(16'h00F3, 8'h66); lr(16'h00F2);
        lw(16'h00F2, 8'h7F); lr(16'h00F3); lw(16'h00F3, 8'h01);
        // R10 auxiliary bytes
        lw(16'h00F8, 8'h3C); lw(16'h00F9, 8'hC3); lr(16'h00F8); lr(16'h00F9);
        // R12 target strobes, R3 read-back zero
        lw(16'h00FA, 8'h10); lw(16'h00FB, 8'h20); lw(16'h00FC, 8'h30);
        lr(16'h00FA); lr(16'h00FB); lr(16'h00FC);
        // R11 outside the window
        lw(16'h01F4, 8'hEE); lw(16'h00E8, 8'hEE); lw(16'h00FD, 8'hEE);
        lr(16'h00E4); lr(16'h00FD); lr(16'h10F2); hr(2'd0);
        // Mixed random phase
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a = (lf[7:4] == 4'h0) ? {8'h01, 4'hF, lf[3:0]} : {8'h00, 4'hF, lf[3:0]};
            step(a, lf[23:16], lf[9:8] == 2'd1, lf[9], lf[10] & lf[11],
                 lf[15:14], lf[12], lf[13], lf[31:24]);
        end
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule